// File: doc/BRIEF.md
# I2C Bit-Level Master Engine

This block carries out one I2C bus primitive per command on an open-drain clock and data pair. The primitives are start, repeated start, stop, byte write with acknowledge capture, byte read, and the master's ACK or NACK. The block drives each line only as an output enable: 1 pulls the line low and 0 releases it. Both lines are read back through a synchronizer. A controller above it, which handles messages, addressing and retries, issues one command, waits for the done strobe, then reads back the received byte, the acknowledge flag or the error flag.

Timing comes from a run-time period value counted in system clock cycles. After a data-line change the engine waits half the period, rounded up. After it pulls the clock low it waits half the period, rounded down. A released clock stays high for one full period.

Before that high time starts, the engine waits until the clock line reads back high, so a slave can stretch the clock. The wait is bounded by a programmable timeout. When the timeout expires the engine samples the line one final time, and only then does it abort. A mode input skips the read-back wait for buses where the clock cannot be sensed.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset both output enables are 0 (lines released), and `busy_o`, `done_o` and `err_o` are 0.
- R2: Command 1 (start) with both synchronized lines high pulls SDA low, then pulls SCL low exactly period+2 cycles later, with no stretch wait. If either line reads low, the command ends with `done_o` and `err_o` and changes neither line.
- R3: Command 3 (stop) pulls SDA low, clocks SCL high, then releases SDA while SCL is high, which forms a stop condition. It ends with both lines released.
- R4: Command 2 (repeated start) releases SDA, clocks SCL high, then pulls SDA low while SCL is high, which forms a start condition. It ends with SCL driven low.
- R5: Command 4 (write) puts `wdata_i` on SDA MSB first, one bit per SCL high, then releases SDA for a ninth clock. `ack_o` becomes 1 exactly when SDA read low on that ninth clock.
- R6: Command 5 (read) releases SDA and samples it on 8 SCL highs, MSB first, into `rdata_o`.
- R7: Command 6 (ack phase) drives SDA low for one SCL clock when `ack_sel_i` is 1 and leaves it released when `ack_sel_i` is 0.
- R8: Within a write, each SCL low phase between clocks lasts floor(period/2)+2 + ceil(period/2)+2 cycles, which is period+4.
- R9: Without stretching, each SCL high phase lasts period+SYNC_STAGES+3 cycles. With `no_sense_i`=1 it lasts period+2 cycles.
- R10: While a slave holds SCL low, the engine keeps SCL released. It pulls SCL low again exactly period+SYNC_STAGES+3 cycles after the line actually rises.
- R11: If SCL stays low past `timeout_i` cycles and one final sample, the command aborts: `done_o` pulses, `err_o` sets and holds, and SCL is driven low. The next accepted command clears `err_o`.
- R12: During a read, each SCL low phase between bits lasts period+2 cycles. `done_o` rises floor(period/2)+2 cycles after the final SCL fall.
- R13: Command codes 0 and 7, and any command offered while busy, are ignored: no `busy_o`, no `done_o`, no line change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe, taken when idle |
| cmd_i | input | 3 | Command code 1..6 |
| wdata_i | input | 8 | Byte to write |
| ack_sel_i | input | 1 | 1 = send ACK, 0 = send NACK |
| period_i | input | DLY_W | Bus period in clock cycles |
| timeout_i | input | TMO_W | Clock-stretch limit in cycles |
| no_sense_i | input | 1 | 1 = skip SCL read-back wait |
| scl_i | input | 1 | SCL line read-back |
| sda_i | input | 1 | SDA line read-back |
| scl_oe_o | output | 1 | 1 = pull SCL low |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion strobe |
| rdata_o | output | 8 | Byte received by read |
| ack_o | output | 1 | 1 = slave acknowledged last write |
| err_o | output | 1 | Sticky timeout / bus-busy error |

## Verification
The bench builds the engine with DLY_W=6, TMO_W=8 and SYNC_STAGES=2. A 6-bit period keeps every phase short enough that random bytes are exercised at both odd and even periods, where the rounded-up and rounded-down half delays differ. An 8-bit timeout, set to 40 cycles, lets a permanently held clock reach the abort path within a few dozen cycles. The same bench also includes a 20-cycle stretch that stays below that limit, so the delayed high-time restart is checked exactly.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;

  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_START   = 3'd1,
    CMD_RESTART = 3'd2,
    CMD_STOP    = 3'd3,
    CMD_WRITE   = 3'd4,
    CMD_READ    = 3'd5,
    CMD_ACKNAK  = 3'd6,
    CMD_RSVD    = 3'd7
  } cmd_e;

  // micro-operations: line effect plus the delay that follows it
  typedef enum logic [3:0] {
    OP_SDA_LO_H,   // pull SDA, ceil half
    OP_SDA_HI_H,   // release SDA, ceil half
    OP_SDA_BIT_H,  // data bit on SDA, ceil half
    OP_SDA_ACK_H,  // ack select on SDA, ceil half
    OP_SDA_LO_F,   // pull SDA, full period
    OP_SDA_HI_F,   // release SDA, full period
    OP_SCL_LO_H,   // pull SCL, floor half
    OP_SCL_LO_T,   // pull SCL, full or floor half on last read bit
    OP_SCL_HI,     // release SCL, wait for rise, full period
    OP_END
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_EXEC,
    PH_DELAY,
    PH_STRETCH,
    PH_LAST
  } phase_e;

  localparam logic [2:0] WR_LOOP_END  = 3'd2;
  localparam logic [2:0] WR_ACK_STEP  = 3'd4;
  localparam logic [2:0] RD_LOOP_HEAD = 3'd1;
  localparam logic [2:0] RD_LOOP_END  = 3'd2;

  function automatic op_e seq_op(cmd_e c, logic [2:0] s);
    op_e o;
    o = OP_END;
    unique case (c)
      CMD_START: case (s)
        3'd0: o = OP_SDA_LO_F;
        3'd1: o = OP_SCL_LO_H;
        default: o = OP_END;
      endcase
      CMD_RESTART: case (s)
        3'd0: o = OP_SDA_HI_H;
        3'd1: o = OP_SCL_HI;
        3'd2: o = OP_SDA_LO_F;
        3'd3: o = OP_SCL_LO_H;
        default: o = OP_END;
      endcase
      CMD_STOP: case (s)
        3'd0: o = OP_SDA_LO_H;
        3'd1: o = OP_SCL_HI;
        3'd2: o = OP_SDA_HI_F;
        default: o = OP_END;
      endcase
      CMD_WRITE: case (s)
        3'd0: o = OP_SDA_BIT_H;
        3'd1: o = OP_SCL_HI;
        3'd2: o = OP_SCL_LO_H;
        3'd3: o = OP_SDA_HI_H;
        3'd4: o = OP_SCL_HI;
        3'd5: o = OP_SCL_LO_H;
        default: o = OP_END;
      endcase
      CMD_READ: case (s)
        3'd0: o = OP_SDA_HI_H;
        3'd1: o = OP_SCL_HI;
        3'd2: o = OP_SCL_LO_T;
        default: o = OP_END;
      endcase
      CMD_ACKNAK: case (s)
        3'd0: o = OP_SDA_ACK_H;
        3'd1: o = OP_SCL_HI;
        3'd2: o = OP_SCL_LO_H;
        default: o = OP_END;
      endcase
      default: o = OP_END;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/i2c_bit_sync.sv
module i2c_bit_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_bit_down_cnt.sv
module i2c_bit_down_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= val_i;
    else if (dec_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_bit_pkg::*;
#(
  parameter int DLY_W       = 8,
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_i,
  input  logic [7:0]       wdata_i,
  input  logic             ack_sel_i,
  input  logic [DLY_W-1:0] period_i,
  input  logic [TMO_W-1:0] timeout_i,
  input  logic             no_sense_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [7:0]       rdata_o,
  output logic             ack_o,
  output logic             err_o
);

  phase_e     phase_q;
  cmd_e       cmd_q;
  logic [2:0] step_q, bit_q;
  logic [7:0] wdata_q, rdata_q;
  logic       ack_sel_q, scl_oe_q, sda_oe_q, done_q, err_q, ack_q;
  logic       scl_s, sda_s;
  op_e        op;

  i2c_bit_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
  );

  logic [DLY_W:0]   per_inc;
  logic [DLY_W-1:0] half_up, half_dn, dly_val;
  assign per_inc = {1'b0, period_i} + 1'b1;
  assign half_up = per_inc[DLY_W:1];
  assign half_dn = period_i >> 1;

  assign op = seq_op(cmd_q, step_q);

  always_comb begin
    unique case (op)
      OP_SDA_LO_H, OP_SDA_HI_H, OP_SDA_BIT_H, OP_SDA_ACK_H: dly_val = half_up;
      OP_SDA_LO_F, OP_SDA_HI_F, OP_SCL_HI:                  dly_val = period_i;
      OP_SCL_LO_H:                                          dly_val = half_dn;
      OP_SCL_LO_T: dly_val = (bit_q == 3'd0) ? half_dn : period_i;
      default:     dly_val = '0;
    endcase
  end

  logic cmd_ok, start_fail, dly_load, dly_zero, tmo_load, tmo_dec, tmo_zero;
  assign cmd_ok     = cmd_valid_i && (cmd_i != CMD_NONE) && (cmd_i != CMD_RSVD);
  assign start_fail = (phase_q == PH_EXEC) && (cmd_q == CMD_START) &&
                      (step_q == 3'd0) && !(scl_s && sda_s);
  assign dly_load   = ((phase_q == PH_EXEC) && !start_fail && (op != OP_END) &&
                       !((op == OP_SCL_HI) && !no_sense_i)) ||
                      (((phase_q == PH_STRETCH) || (phase_q == PH_LAST)) && scl_s);
  assign tmo_load   = (phase_q == PH_EXEC) && (op == OP_SCL_HI);
  assign tmo_dec    = (phase_q == PH_STRETCH) && !scl_s;

  i2c_bit_down_cnt #(.W(DLY_W)) i_dly (
    .clk_i, .rst_ni, .load_i(dly_load), .val_i(dly_val),
    .dec_i(phase_q == PH_DELAY), .zero_o(dly_zero)
  );

  i2c_bit_down_cnt #(.W(TMO_W)) i_tmo (
    .clk_i, .rst_ni, .load_i(tmo_load), .val_i(timeout_i),
    .dec_i(tmo_dec), .zero_o(tmo_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      cmd_q     <= CMD_NONE;
      step_q    <= '0;
      bit_q     <= '0;
      wdata_q   <= '0;
      ack_sel_q <= 1'b0;
      scl_oe_q  <= 1'b0;
      sda_oe_q  <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      rdata_q   <= '0;
      ack_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (cmd_ok) begin
          cmd_q     <= cmd_e'(cmd_i);
          wdata_q   <= wdata_i;
          ack_sel_q <= ack_sel_i;
          step_q    <= '0;
          bit_q     <= 3'd7;
          err_q     <= 1'b0;
          phase_q   <= PH_EXEC;
        end
        PH_EXEC: begin
          if (start_fail) begin
            err_q   <= 1'b1;
            done_q  <= 1'b1;
            phase_q <= PH_IDLE;
          end else begin
            phase_q <= PH_DELAY;
            unique case (op)
              OP_END: begin
                done_q  <= 1'b1;
                phase_q <= PH_IDLE;
              end
              OP_SCL_HI: begin
                scl_oe_q <= 1'b0;
                if (!no_sense_i) phase_q <= PH_STRETCH;
              end
              OP_SDA_LO_H, OP_SDA_LO_F: sda_oe_q <= 1'b1;
              OP_SDA_HI_H, OP_SDA_HI_F: sda_oe_q <= 1'b0;
              OP_SDA_BIT_H:             sda_oe_q <= ~wdata_q[bit_q];
              OP_SDA_ACK_H:             sda_oe_q <= ack_sel_q;
              OP_SCL_LO_H, OP_SCL_LO_T: scl_oe_q <= 1'b1;
              default: ;
            endcase
          end
        end
        PH_DELAY: if (dly_zero) begin
          if (op == OP_SCL_HI) begin
            if (cmd_q == CMD_READ) rdata_q <= {rdata_q[6:0], sda_s};
            if (cmd_q == CMD_WRITE && step_q == WR_ACK_STEP) ack_q <= ~sda_s;
          end
          if (cmd_q == CMD_WRITE && step_q == WR_LOOP_END && bit_q != 3'd0) begin
            step_q <= '0;
            bit_q  <= bit_q - 1'b1;
          end else if (cmd_q == CMD_READ && step_q == RD_LOOP_END && bit_q != 3'd0) begin
            step_q <= RD_LOOP_HEAD;
            bit_q  <= bit_q - 1'b1;
          end else begin
            step_q <= step_q + 1'b1;
          end
          phase_q <= PH_EXEC;
        end
        PH_STRETCH: begin
          if (scl_s)         phase_q <= PH_DELAY;
          else if (tmo_zero) phase_q <= PH_LAST;
        end
        PH_LAST: begin
          if (scl_s) phase_q <= PH_DELAY;
          else begin
            scl_oe_q <= 1'b1;
            err_q    <= 1'b1;
            done_q   <= 1'b1;
            phase_q  <= PH_IDLE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign scl_oe_o = scl_oe_q;
  assign sda_oe_o = sda_oe_q;
  assign busy_o   = (phase_q != PH_IDLE);
  assign done_o   = done_q;
  assign rdata_o  = rdata_q;
  assign ack_o    = ack_q;
  assign err_o    = err_q;

  a_r10_released_while_waiting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_STRETCH || phase_q == PH_LAST) |-> !scl_oe_q);

  a_r11_abort_drives_scl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_LAST && !scl_s) |=> (scl_oe_q && err_q && done_q));

  a_r5_sda_stable_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE && $past(phase_q != PH_IDLE) &&
     (cmd_q == CMD_WRITE || cmd_q == CMD_READ || cmd_q == CMD_ACKNAK) &&
     !scl_oe_q && $past(!scl_oe_q)) |-> $stable(sda_oe_q));

  a_r13_done_from_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(phase_q == PH_EXEC || phase_q == PH_LAST));

  a_r2_busy_start_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_fail |=> ($stable(sda_oe_q) && $stable(scl_oe_q) && err_q && !busy_o));

  a_r9_no_sense_skips_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_EXEC && op == OP_SCL_HI && no_sense_i) |=> (phase_q == PH_DELAY));

endmodule

// File: tb/test_i2c_bit_engine.sv
module test_i2c_bit_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DLY_W = 6;
  localparam int TMO_W = 8;
  localparam int SYNC  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic             cmd_valid_i = 1'b0;
  logic [2:0]       cmd_i = '0;
  logic [7:0]       wdata_i = '0;
  logic             ack_sel_i = 1'b0;
  logic [DLY_W-1:0] period_i = 6'd4;
  logic [TMO_W-1:0] timeout_i = 8'd40;
  logic             no_sense_i = 1'b0;
  logic             scl_oe_o, sda_oe_o, busy_o, done_o, ack_o, err_o;
  logic [7:0]       rdata_o;
  logic             scl_hold = 1'b0, sda_hold = 1'b0, slave_low = 1'b0;
  logic             scl_line, sda_line;

  assign scl_line = !scl_oe_o && !scl_hold;
  assign sda_line = !sda_oe_o && !sda_hold && !slave_low;

  i2c_bit_engine #(.DLY_W(DLY_W), .TMO_W(TMO_W), .SYNC_STAGES(SYNC)) i_i2c_bit_engine (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i, .cmd_i, .wdata_i, .ack_sel_i,
    .period_i, .timeout_i, .no_sense_i, .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o, .sda_oe_o, .busy_o, .done_o, .rdata_o, .ack_o, .err_o
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_wr_low(input int p);  return p + 4; endfunction
  function automatic int exp_high(input int p, input bit ns); return ns ? p + 2 : p + SYNC + 3; endfunction
  function automatic int exp_rd_low(input int p);  return p + 2; endfunction
  function automatic int exp_rd_tail(input int p); return p / 2 + 2; endfunction

  // SCL phase timing monitor
  int t_lo = 0, t_rel = 0, t_sda_lo = 0, n_low = 0, n_high = 0;
  int low_d [16];
  int high_d[16];
  logic prev_scl = 1'b0, prev_sda = 1'b0;
  always @(negedge clk) begin
    if (scl_oe_o !== prev_scl) begin
      if (scl_oe_o) begin
        if (n_high < 16) high_d[n_high] = cyc - t_rel;
        n_high++;
        t_lo = cyc;
      end else begin
        if (n_low < 16) low_d[n_low] = cyc - t_lo;
        n_low++;
        t_rel = cyc;
      end
      prev_scl = scl_oe_o;
    end
    if (sda_oe_o !== prev_sda) begin
      if (sda_oe_o) t_sda_lo = cyc;
      prev_sda = sda_oe_o;
    end
  end

  // bus monitor
  int starts = 0, stops = 0, mon_cnt = 0;
  logic [8:0] mon_shift = '0;
  always @(negedge sda_line) if (scl_line === 1'b1) starts++;
  always @(posedge sda_line) if (scl_line === 1'b1) stops++;
  always @(posedge scl_line) begin
    mon_shift = {mon_shift[7:0], sda_line};
    mon_cnt++;
  end

  // slave model: 0 passive, 1 acknowledge writes, 2 supply read byte
  int slv_mode = 0, fall_cnt = 0;
  logic slv_ack = 1'b0;
  logic [7:0] slv_byte = '0;
  always @(negedge scl_line) begin
    fall_cnt++;
    if (slv_mode == 2) slave_low = (fall_cnt < 8) ? !slv_byte[7 - fall_cnt] : 1'b0;
    else if (slv_mode == 1) slave_low = (fall_cnt == 8) ? slv_ack : 1'b0;
  end

  task automatic send_cmd(input logic [2:0] c, input logic [7:0] wd, input logic as);
    @(negedge clk);
    cmd_i = c; wdata_i = wd; ack_sel_i = as; cmd_valid_i = 1'b1;
    n_low = 0; n_high = 0; mon_cnt = 0;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic wait_done(output int t_done);
    bit seen = 1'b0;
    t_done = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (done_o) begin seen = 1'b1; t_done = cyc; break; end
    end
    if (!seen) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1 (done_o)");
    end
  endtask

  task automatic do_write(input int p, input bit ns, input logic [7:0] b, input logic a);
    int td;
    period_i = p[DLY_W-1:0]; no_sense_i = ns;
    slv_mode = 1; slv_ack = a; fall_cnt = 0; slave_low = 1'b0;
    send_cmd(3'd4, b, 1'b0);
    wait_done(td);
    chk("R5 clocks", mon_cnt, 9);
    chk("R5 byte", int'(mon_shift[8:1]), int'(b));
    chk("R5 ack_o", int'(ack_o), int'(a));
    for (int k = 1; k <= 8; k++) chk("R8 low time", low_d[k], exp_wr_low(p));
    for (int k = 0; k <= 8; k++) chk("R9 high time", high_d[k], exp_high(p, ns));
    slv_mode = 0;
  endtask

  task automatic do_read(input int p, input logic [7:0] b);
    int td;
    period_i = p[DLY_W-1:0]; no_sense_i = 1'b0;
    slv_mode = 2; slv_byte = b; fall_cnt = 0;
    @(negedge clk); slave_low = !b[7];
    send_cmd(3'd5, 8'h00, 1'b0);
    wait_done(td);
    chk("R6 clocks", mon_cnt, 8);
    chk("R6 rdata_o", int'(rdata_o), int'(b));
    for (int k = 1; k <= 7; k++) chk("R12 low time", low_d[k], exp_rd_low(p));
    chk("R12 tail", td - t_lo, exp_rd_tail(p));
    slv_mode = 0; slave_low = 1'b0;
  endtask

  task automatic do_acknak(input int p, input logic sel);
    int td;
    period_i = p[DLY_W-1:0];
    send_cmd(3'd6, 8'h00, sel);
    wait_done(td);
    chk("R7 clocks", mon_cnt, 1);
    chk("R7 sda on clock", int'(mon_shift[0]), int'(!sel));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int td, s0, r, seen;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1 scl_oe", int'(scl_oe_o), 0);
    chk("R1 sda_oe", int'(sda_oe_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 err", int'(err_o), 0);

    // start on a busy bus
    sda_hold = 1'b1;
    repeat (5) @(negedge clk);
    s0 = starts;
    send_cmd(3'd1, 8'h00, 1'b0);
    wait_done(td);
    chk("R2 busy err", int'(err_o), 1);
    chk("R2 busy sda", int'(sda_oe_o), 0);
    chk("R2 busy scl", int'(scl_oe_o), 0);
    sda_hold = 1'b0;
    repeat (5) @(negedge clk);

    // start timing
    period_i = 6'd5;
    send_cmd(3'd1, 8'h00, 1'b0);
    wait_done(td);
    chk("R2 start cond", starts - s0, 1);
    chk("R2 start hold", t_lo - t_sda_lo, 5 + 2);
    chk("R11 err cleared", int'(err_o), 0);

    // directed corners then random mix
    do_write(3, 1'b0, 8'h80, 1'b1);
    do_write(6, 1'b0, 8'h01, 1'b0);
    do_read(7, 8'hFF);
    do_acknak(7, 1'b1);
    do_read(2, 8'h00);
    do_acknak(2, 1'b0);
    for (int it = 0; it < 10; it++) begin
      int p = 2 + int'($urandom_range(0, 9));
      if ($urandom_range(0, 1) == 0)
        do_write(p, 1'b0, 8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)));
      else begin
        do_read(p, 8'($urandom_range(0, 255)));
        do_acknak(p, 1'($urandom_range(0, 1)));
      end
    end

    // repeated start
    s0 = starts;
    period_i = 6'd4;
    send_cmd(3'd2, 8'h00, 1'b0);
    wait_done(td);
    chk("R4 restart cond", starts - s0, 1);
    chk("R4 scl low after", int'(scl_oe_o), 1);

    // no read-back mode
    do_write(5, 1'b1, 8'hC3, 1'b1);

    // clock stretch
    period_i = 6'd4; no_sense_i = 1'b0;
    slv_mode = 1; slv_ack = 1'b1; fall_cnt = 0; slave_low = 1'b0;
    scl_hold = 1'b1;
    send_cmd(3'd4, 8'hA5, 1'b0);
    for (int i = 0; i < 200 && scl_oe_o; i++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk("R10 kept released", int'(scl_oe_o), 0);
    scl_hold = 1'b0;
    r = cyc;
    for (int i = 0; i < 200 && !scl_oe_o; i++) @(negedge clk);
    chk("R10 stretch high", cyc - r, exp_high(4, 1'b0));
    wait_done(td);
    chk("R10 byte", int'(mon_shift[8:1]), 8'hA5);
    chk("R10 ack", int'(ack_o), 1);
    slv_mode = 0;

    // timeout
    scl_hold = 1'b1;
    send_cmd(3'd4, 8'h5A, 1'b0);
    wait_done(td);
    chk("R11 err", int'(err_o), 1);
    chk("R11 scl driven", int'(scl_oe_o), 1);
    repeat (4) @(negedge clk);
    chk("R11 err sticky", int'(err_o), 1);
    scl_hold = 1'b0;

    // stop
    s0 = stops;
    send_cmd(3'd3, 8'h00, 1'b0);
    wait_done(td);
    chk("R11 err cleared by cmd", int'(err_o), 0);
    chk("R3 stop cond", stops - s0, 1);
    chk("R3 scl released", int'(scl_oe_o), 0);
    chk("R3 sda released", int'(sda_oe_o), 0);

    // ignored codes
    seen = 0;
    send_cmd(3'd0, 8'h00, 1'b0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (busy_o || done_o || scl_oe_o || sda_oe_o) seen++;
    end
    send_cmd(3'd7, 8'h00, 1'b0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (busy_o || done_o || scl_oe_o || sda_oe_o) seen++;
    end
    chk("R13 ignored codes", seen, 0);

    // command offered while busy
    s0 = starts;
    send_cmd(3'd1, 8'h00, 1'b0);
    send_cmd(3'd3, 8'h00, 1'b0);
    wait_done(td);
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (busy_o || done_o) seen++;
    end
    chk("R13 busy cmd dropped", seen, 0);
    chk("R13 start only", starts - s0, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule